// File: doc/BRIEF.md
# Modem Status Register with Change Flags

This block keeps the eight-bit modem status word of a serial port. Four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) are each passed through a two-flop synchronizer. The upper nibble of the word reports whether each line is asserted. The lower nibble holds sticky change flags that software clears by reading the word. A modem-status interrupt request is raised when software has enabled it and a qualifying flag is pending. A clear-to-send change does not raise the request while hardware transmit flow control (auto clear-to-send) is switched on.

The register bus decoding sits outside the block. It presents `statusWord` on a read and pulses `rdStrobe` for one clock during that read. The interrupt priority encoder consumes `msIrq`.

Top module: `modem_status_reg`

## Requirements
- R1: Bits 7..4 of `statusWord` report the asserted state of the lines, which is the complement of the pin level: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring indicator, bit 7 carrier detect. A pin change shows in these bits two clocks after it is sampled.
- R2: Bit 0 is set when the clear-to-send pin changes in either direction, one clock after the new level shows in bit 4.
- R3: Bit 1 is set on any change of the data-set-ready pin, with the same timing as R2.
- R4: Bit 3 is set on any change of the carrier-detect pin, with the same timing as R2.
- R5: Bit 2 is set only when the ring-indicator pin goes from low to high, which is the end of a ring. A high-to-low change of that pin leaves bit 2 unchanged.
- R6: A clock edge that samples `rdStrobe` high clears bits 3..0. Bits 7..4 are not affected by the read.
- R7: A change whose flag would be set on the same edge as a read clear is kept. The flag reads as set after the read.
- R8: With `msIntEn` high, `msIrq` is high whenever bit 1, 2 or 3 is set, or bit 0 is set while `autoCtsEn` is low.
- R9: While `autoCtsEn` is high, a clear-to-send change still sets bit 0 but does not drive `msIrq` high by itself.
- R10: `msIrq` is low while `msIntEn` is low, whatever the flags hold. It rises without delay once the enable is set while a flag is pending.
- R11: Reset (`rst` high) clears all change flags and `msIrq`. During reset bits 7..4 read as all lines deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring-indicator pin, active low |
| dcdN | input | 1 | Carrier-detect pin, active low |
| rdStrobe | input | 1 | One-clock pulse marking a read of the word |
| msIntEn | input | 1 | Modem-status interrupt enable |
| autoCtsEn | input | 1 | Hardware transmit flow control active; masks clear-to-send changes from the interrupt |
| statusWord | output | 8 | Modem status word: line states in 7..4, change flags in 3..0 |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a read that lands on the very clock edge where a new change flag is being set. The edge detector runs two synchronizer stages behind the pin, so the stimulus changes a pin and then counts exactly two rising edges before it raises `rdStrobe` for one cycle. An older pending flag is set beforehand, so one read shows both effects: the old flag is cleared and the new one is kept. The ring-indicator test drives the pin both ways and checks that only the trailing edge is flagged.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINE_COUNT = 4;
  localparam int LINE_CTS = 0;
  localparam int LINE_DSR = 1;
  localparam int LINE_RI  = 2;
  localparam int LINE_DCD = 3;

  typedef struct packed {
    logic [LINE_COUNT-1:0] setFlag;
    logic                  clearAll;
  } msr_strobes_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : gLine
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], asyncIn[g]};
      end
      assign syncOut[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic [LINE_COUNT-1:0] curLvl,
  input  logic [LINE_COUNT-1:0] prevLvl,
  input  logic                  rdStrobe,
  output msr_strobes_t          strobes
);
  logic [LINE_COUNT-1:0] toggled;

  always_comb begin
    toggled = curLvl ^ prevLvl;
    strobes.setFlag = toggled;
    // ring indicator flags only the pin rising (ring ends)
    strobes.setFlag[LINE_RI] = curLvl[LINE_RI] & ~prevLvl[LINE_RI];
    strobes.clearAll = rdStrobe;
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINE_COUNT-1:0] pinsN,
  input  msr_strobes_t          strobes,
  input  logic                  msIntEn,
  input  logic                  autoCtsEn,
  output logic [LINE_COUNT-1:0] curLvl,
  output logic [LINE_COUNT-1:0] prevLvl,
  output logic [2*LINE_COUNT-1:0] statusWord,
  output logic                  msIrq
);
  logic [LINE_COUNT-1:0] flags;
  logic [LINE_COUNT-1:0] irqMask;

  msr_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (pinsN),
    .syncOut (curLvl)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prevLvl <= '1;
    else     prevLvl <= curLvl;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                   flags <= '0;
    else if (strobes.clearAll) flags <= strobes.setFlag;
    else                       flags <= flags | strobes.setFlag;
  end

  always_comb begin
    irqMask = '1;
    irqMask[LINE_CTS] = ~autoCtsEn;
  end

  assign statusWord = {~curLvl, flags};
  assign msIrq      = msIntEn & (|(flags & irqMask));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  input  logic       rdStrobe,
  input  logic       msIntEn,
  input  logic       autoCtsEn,
  output logic [7:0] statusWord,
  output logic       msIrq
);
  logic [LINE_COUNT-1:0] pinsN;
  logic [LINE_COUNT-1:0] curLvl;
  logic [LINE_COUNT-1:0] prevLvl;
  msr_strobes_t          strobes;

  always_comb begin
    pinsN = '0;
    pinsN[LINE_CTS] = ctsN;
    pinsN[LINE_DSR] = dsrN;
    pinsN[LINE_RI]  = riN;
    pinsN[LINE_DCD] = dcdN;
  end

  msr_ctrl u_ctrl (
    .curLvl   (curLvl),
    .prevLvl  (prevLvl),
    .rdStrobe (rdStrobe),
    .strobes  (strobes)
  );

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .pinsN      (pinsN),
    .strobes    (strobes),
    .msIntEn    (msIntEn),
    .autoCtsEn  (autoCtsEn),
    .curLvl     (curLvl),
    .prevLvl    (prevLvl),
    .statusWord (statusWord),
    .msIrq      (msIrq)
  );
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] pinsN,
  input logic       rdStrobe,
  input logic       msIntEn,
  input logic       autoCtsEn,
  input logic [7:0] statusWord,
  input logic       msIrq
);
  AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2)) |-> statusWord[7:4] == ~$past(pinsN, 2)); // R1

  AST_CTS_CHANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$stable(statusWord[4]) |=> statusWord[0]); // R2

  AST_DSR_CHANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$stable(statusWord[5]) |=> statusWord[1]); // R3

  AST_DCD_CHANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$stable(statusWord[7]) |=> statusWord[3]); // R4

  AST_RI_TRAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(statusWord[6]) |=> statusWord[2]); // R5

  AST_RI_LEAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($rose(statusWord[6]) && !statusWord[2]) |=> !statusWord[2]); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && $stable(statusWord[7:4])) |=> statusWord[3:0] == 4'h0); // R6

  AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
    (msIntEn && statusWord[3:1] != 3'b000) |-> msIrq); // R8

  AST_CTS_MASKED: assert property (@(posedge clk) disable iff (rst)
    (autoCtsEn && statusWord[3:1] == 3'b000) |-> !msIrq); // R9

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !msIntEn |-> !msIrq); // R10
endmodule

bind modem_status_reg msr_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .pinsN      ({dcdN, riN, dsrN, ctsN}),
  .rdStrobe   (rdStrobe),
  .msIntEn    (msIntEn),
  .autoCtsEn  (autoCtsEn),
  .statusWord (statusWord),
  .msIrq      (msIrq)
);

// File: tb/test_modem_status_reg.sv
`timescale 1ns/1ps
module test_modem_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic rdStrobe = 1'b0, msIntEn = 1'b0, autoCtsEn = 1'b0;
  logic [7:0] statusWord;
  logic msIrq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  modem_status_reg i_modem_status_reg (
    .clk(clk), .rst(rst), .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .rdStrobe(rdStrobe), .msIntEn(msIntEn), .autoCtsEn(autoCtsEn),
    .statusWord(statusWord), .msIrq(msIrq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkWord(input string req, input logic [7:0] exp);
    checks++;
    if (statusWord !== exp) begin
      errors++;
      $display("FAIL %s statusWord actual=%02h expected=%02h", req, statusWord, exp);
    end
  endtask

  task automatic checkIrq(input string req, input logic exp);
    checks++;
    if (msIrq !== exp) begin
      errors++;
      $display("FAIL %s msIrq actual=%0b expected=%0b", req, msIrq, exp);
    end
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    tick(1);
    rdStrobe = 1'b0;
  endtask

  task automatic testReset();
    checkWord("R11", 8'h00);
    checkIrq("R11", 1'b0);
  endtask

  task automatic testCts();
    msIntEn = 1'b1;
    ctsN = 1'b0;
    tick(1); checkWord("R1", 8'h00);
    tick(1); checkWord("R1", 8'h10);
    tick(1); checkWord("R2", 8'h11); checkIrq("R8", 1'b1);
    doRead(); checkWord("R6", 8'h10); checkIrq("R6", 1'b0);
  endtask

  task automatic testDsr();
    dsrN = 1'b0; tick(3); checkWord("R3", 8'h32);
    dsrN = 1'b1; tick(3); checkWord("R3", 8'h12);
    doRead(); checkWord("R6", 8'h10);
  endtask

  task automatic testDcd();
    dcdN = 1'b0; tick(3); checkWord("R4", 8'h98); checkIrq("R4", 1'b1);
    doRead(); checkWord("R6", 8'h90);
    dcdN = 1'b1; tick(3); checkWord("R4", 8'h18);
    doRead(); checkWord("R6", 8'h10);
  endtask

  task automatic testRi();
    riN = 1'b0; tick(3); checkWord("R5", 8'h50); checkIrq("R5", 1'b0);
    riN = 1'b1; tick(3); checkWord("R5", 8'h14); checkIrq("R5", 1'b1);
    doRead(); checkWord("R6", 8'h10);
  endtask

  task automatic testReadCollision();
    ctsN = 1'b1; tick(3); checkWord("R2", 8'h01);
    dsrN = 1'b0; tick(2);
    doRead(); checkWord("R7", 8'h22);
    doRead(); checkWord("R6", 8'h20);
    dsrN = 1'b1; tick(3); checkWord("R3", 8'h02);
    doRead(); checkWord("R6", 8'h00);
  endtask

  task automatic testAutoCts();
    autoCtsEn = 1'b1;
    ctsN = 1'b0; tick(3); checkWord("R9", 8'h11); checkIrq("R9", 1'b0);
    dcdN = 1'b0; tick(3); checkWord("R9", 8'h99); checkIrq("R9", 1'b1);
    doRead(); checkWord("R6", 8'h90);
    dcdN = 1'b1; tick(3); doRead(); checkWord("R6", 8'h10);
    autoCtsEn = 1'b0;
  endtask

  task automatic testEnable();
    msIntEn = 1'b0;
    ctsN = 1'b1; tick(3); checkWord("R10", 8'h01); checkIrq("R10", 1'b0);
    msIntEn = 1'b1; #1; checkIrq("R10", 1'b1);
    tick(0); doRead(); checkWord("R6", 8'h00); checkIrq("R10", 1'b0);
  endtask

  task automatic testMidReset();
    dsrN = 1'b0; tick(3); checkWord("R3", 8'h22); checkIrq("R8", 1'b1);
    rst = 1'b1; #1;
    checkWord("R11", 8'h00); checkIrq("R11", 1'b0);
    dsrN = 1'b1; tick(2);
    rst = 1'b0; tick(3);
    checkWord("R11", 8'h00); checkIrq("R11", 1'b0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    testReset();
    testCts();
    testDsr();
    testDcd();
    testRi();
    testReadCollision();
    testAutoCts();
    testEnable();
    testMidReset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule